// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the SD card clock from a faster base clock by two divide stages in series. The first stage is a power-of-two prescaler, and the second is a linear divisor of 1 to 16. Software programs the two divide fields while the card clock is stopped. It then raises the card-clock enable and the peripheral-clock enable together. The block then produces a one-cycle tick at the divided rate and a registered card clock line that changes level on every tick. It also raises a settled flag a fixed time after start-up.

The prescaler field holds a coded value, not the ratio itself. In single data rate mode the field holds half the ratio. In double data rate mode it holds a quarter of the ratio. The divisor field holds the ratio minus one. The divide settings are copied into an internal register only while the clock is stopped. A field write while the clock runs therefore cannot disturb the output, and the card clock can only change level at a divider terminal count.

Top module: `sdclk_divider`

## Requirements
- R1: While `rst` is high, and after it is released with both enables low, `card_clk`, `card_tick` and `clk_stable` are all 0.
- R2: With `ddr_sel`=0, a non-zero `presc_field` whose highest set bit is at position m gives a prescale ratio of 2^(m+1). Lower set bits are ignored, so 0x01 gives 2 and 0x80 gives 256.
- R3: With `ddr_sel`=1, a non-zero `presc_field` whose highest set bit is at position m gives a ratio of 2^(m+2), capped at 256. A `presc_field` of 0 means bypass, with a ratio of 1, in either mode.
- R4: `div_field` holds the divisor ratio minus one, so 0 gives 1 and 15 gives 16.
- R5: After both enables rise, `card_tick` is high for one cycle after every N-th rising clock edge, where N is the prescale ratio times the divisor ratio. The first pulse follows the N-th edge at which both enables are sampled high.
- R6: `card_clk` starts at 0 and inverts in the same cycle as each `card_tick` pulse. It changes at no other time while running.
- R7: The divider runs only while `card_clk_en` and `periph_clk_en` are both high. One edge after either enable is sampled low, `card_tick` and `card_clk` are 0, and they stay 0 while the enables are not both high.
- R8: The divide fields and `ddr_sel` are captured only at edges where the divider is stopped. Changes to them while it runs do not affect the tick period until the divider has been stopped and restarted.
- R9: `clk_stable` becomes 1 after STABLE_CYCLES consecutive edges with both enables high, and is 0 before that.
- R10: `clk_stable` is 0 one edge after either enable is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous reset, active high |
| presc_field | input | PRESC_W | Coded prescale value |
| div_field | input | DIV_W | Divisor ratio minus one |
| ddr_sel | input | 1 | 1 selects the double data rate coding of the prescale field |
| card_clk_en | input | 1 | Card clock enable |
| periph_clk_en | input | 1 | Peripheral clock enable |
| card_clk | output | 1 | Divided card clock level; inverts on each tick |
| card_tick | output | 1 | One-cycle pulse at the divided rate |
| clk_stable | output | 1 | Clock settled flag |

## Verification
The checker checks four properties on every cycle:
- No tick and no settled flag appear while stopped.
- The card clock changes level only together with a tick while running.
- The captured divide settings hold steady for the whole of a run.
- The settled flag never rises before a full settle window of enabled edges.

The exact tick period for each coding of the fields, the bypass and cap cases, the position of the first tick, and the fact that writes made mid-run are ignored can only be shown by the bench's scenarios. The bench measures these as edge counts at the ports.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  // Meaning of the prescale field coding
  typedef enum logic {
    RATE_SDR = 1'b0,
    RATE_DDR = 1'b1
  } rate_e;

  // Extra shift added to the top-bit position of the prescale field
  function automatic int unsigned coding_shift(rate_e mode);
    return (mode == RATE_DDR) ? 32'd2 : 32'd1;
  endfunction

endpackage

// File: rtl/sdclk_cfg_shadow.sv
module sdclk_cfg_shadow
  import sdclk_pkg::*;
#(
  parameter int PRESC_W = 8,
  parameter int DIV_W   = 4,
  parameter int LP_W    = $clog2(PRESC_W + 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               running,
  input  logic [PRESC_W-1:0] presc_field,
  input  logic [DIV_W-1:0]   div_field,
  input  logic               ddr_sel,
  output logic [LP_W-1:0]    cfg_lp,
  output logic [DIV_W-1:0]   cfg_dlim
);

  rate_e           mode;
  logic [LP_W-1:0] lp_calc;

  assign mode = rate_e'(ddr_sel);

  // Decode: log2 of the prescale ratio from the highest set bit
  always_comb begin
    int top;
    int lp;
    top = -1;
    for (int i = 0; i < PRESC_W; i++) begin
      if (presc_field[i]) top = i;
    end
    if (top < 0) begin
      lp = 0;
    end else begin
      lp = top + int'(coding_shift(mode));
      if (lp > PRESC_W) lp = PRESC_W;
    end
    lp_calc = LP_W'(lp);
  end

  // Capture only while stopped
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_lp   <= '0;
      cfg_dlim <= '0;
    end else if (!running) begin
      cfg_lp   <= lp_calc;
      cfg_dlim <= div_field;
    end
  end

endmodule

// File: rtl/sdclk_prescaler.sv
module sdclk_prescaler #(
  parameter int PRESC_W = 8,
  parameter int LP_W    = $clog2(PRESC_W + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            running,
  input  logic [LP_W-1:0] cfg_lp,
  output logic            pre_last
);

  localparam int LIM_W = PRESC_W + 1;

  logic [PRESC_W-1:0] pcnt;
  logic [LIM_W-1:0]   lim_wide;
  logic [PRESC_W-1:0] lim;

  assign lim_wide = (LIM_W'(1) << cfg_lp) - LIM_W'(1);
  assign lim      = lim_wide[PRESC_W-1:0];
  assign pre_last = (pcnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !running || pre_last) pcnt <= '0;
    else                             pcnt <= pcnt + 1'b1;
  end

endmodule

// File: rtl/sdclk_divisor.sv
module sdclk_divisor #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             running,
  input  logic             pre_last,
  input  logic [DIV_W-1:0] cfg_dlim,
  output logic             card_tick,
  output logic             card_clk
);

  logic [DIV_W-1:0] dcnt;
  logic             term;

  assign term = pre_last && (dcnt == cfg_dlim);

  always_ff @(posedge clk) begin
    if (rst || !running) begin
      dcnt      <= '0;
      card_tick <= 1'b0;
      card_clk  <= 1'b0;
    end else begin
      card_tick <= term;
      if (term)          card_clk <= ~card_clk;
      if (term)          dcnt     <= '0;
      else if (pre_last) dcnt     <= dcnt + 1'b1;
    end
  end

endmodule

// File: rtl/sdclk_settle.sv
module sdclk_settle #(
  parameter int STABLE_CYCLES = 16,
  parameter int CNT_W         = $clog2(STABLE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic running,
  output logic clk_stable
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_CYCLES);

  logic [CNT_W-1:0] scnt;
  logic [CNT_W-1:0] scnt_nxt;

  assign scnt_nxt = (scnt == LAST) ? scnt : scnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !running) begin
      scnt       <= '0;
      clk_stable <= 1'b0;
    end else begin
      scnt       <= scnt_nxt;
      clk_stable <= (scnt_nxt == LAST);
    end
  end

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
#(
  parameter int PRESC_W       = 8,
  parameter int DIV_W         = 4,
  parameter int STABLE_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PRESC_W-1:0] presc_field,
  input  logic [DIV_W-1:0]   div_field,
  input  logic               ddr_sel,
  input  logic               card_clk_en,
  input  logic               periph_clk_en,
  output logic               card_clk,
  output logic               card_tick,
  output logic               clk_stable
);

  localparam int LP_W = $clog2(PRESC_W + 2);

  logic             running;
  logic             pre_last;
  logic [LP_W-1:0]  cfg_lp;
  logic [DIV_W-1:0] cfg_dlim;

  assign running = card_clk_en && periph_clk_en;

  sdclk_cfg_shadow #(.PRESC_W(PRESC_W), .DIV_W(DIV_W), .LP_W(LP_W)) u_shadow (
    .clk         (clk),
    .rst         (rst),
    .running     (running),
    .presc_field (presc_field),
    .div_field   (div_field),
    .ddr_sel     (ddr_sel),
    .cfg_lp      (cfg_lp),
    .cfg_dlim    (cfg_dlim)
  );

  sdclk_prescaler #(.PRESC_W(PRESC_W), .LP_W(LP_W)) u_presc (
    .clk      (clk),
    .rst      (rst),
    .running  (running),
    .cfg_lp   (cfg_lp),
    .pre_last (pre_last)
  );

  sdclk_divisor #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .running   (running),
    .pre_last  (pre_last),
    .cfg_dlim  (cfg_dlim),
    .card_tick (card_tick),
    .card_clk  (card_clk)
  );

  sdclk_settle #(.STABLE_CYCLES(STABLE_CYCLES)) u_settle (
    .clk        (clk),
    .rst        (rst),
    .running    (running),
    .clk_stable (clk_stable)
  );

endmodule

// File: rtl/sdclk_divider_chk.sv
module sdclk_divider_chk #(
  parameter int STABLE_CYCLES = 16,
  parameter int LP_W          = 4,
  parameter int DIV_W         = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             card_clk_en,
  input logic             periph_clk_en,
  input logic             card_clk,
  input logic             card_tick,
  input logic             clk_stable,
  input logic [LP_W-1:0]  cfg_lp,
  input logic [DIV_W-1:0] cfg_dlim
);

  localparam int CW = $clog2(STABLE_CYCLES + 1);

  logic          run;
  logic [CW-1:0] run_cnt;

  assign run = card_clk_en && periph_clk_en;

  always_ff @(posedge clk) begin
    if (rst || !run)                    run_cnt <= '0;
    else if (run_cnt != CW'(STABLE_CYCLES)) run_cnt <= run_cnt + 1'b1;
  end

  // R7
  no_tick_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!card_tick && !card_clk));

  // R6
  clk_moves_with_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(card_clk) && $past(run)) |-> card_tick);

  // R8
  cfg_frozen_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> ($stable(cfg_lp) && $stable(cfg_dlim)));

  // R9
  settle_window_chk: assert property (@(posedge clk) disable iff (rst)
    clk_stable |-> (run_cnt == CW'(STABLE_CYCLES)));

  // R10
  stable_drops_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !clk_stable);

endmodule

bind sdclk_divider sdclk_divider_chk #(
  .STABLE_CYCLES (STABLE_CYCLES),
  .LP_W          (LP_W),
  .DIV_W         (DIV_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .card_clk_en   (card_clk_en),
  .periph_clk_en (periph_clk_en),
  .card_clk      (card_clk),
  .card_tick     (card_tick),
  .clk_stable    (clk_stable),
  .cfg_lp        (cfg_lp),
  .cfg_dlim      (cfg_dlim)
);

// File: tb/sdclk_divider_tb.sv
`timescale 1ns/1ps
module sdclk_divider_tb;

  localparam int STABLE = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] presc_field = '0;
  logic [3:0] div_field = '0;
  logic       ddr_sel = 1'b0;
  logic       card_clk_en = 1'b0;
  logic       periph_clk_en = 1'b0;
  logic       card_clk, card_tick, clk_stable;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sdclk_divider #(.PRESC_W(8), .DIV_W(4), .STABLE_CYCLES(STABLE)) u_dut (
    .clk(clk), .rst(rst), .presc_field(presc_field), .div_field(div_field),
    .ddr_sel(ddr_sel), .card_clk_en(card_clk_en), .periph_clk_en(periph_clk_en),
    .card_clk(card_clk), .card_tick(card_tick), .clk_stable(clk_stable));

  // {3'b0, ddr, presc[8], div[4], expected N[16]}
  localparam int NV = 10;
  localparam logic [31:0] VEC [NV] = '{
    {3'b0, 1'b0, 8'h00, 4'd0,  16'd1},    // R3 bypass
    {3'b0, 1'b0, 8'h01, 4'd0,  16'd2},    // R2
    {3'b0, 1'b0, 8'h01, 4'd3,  16'd8},    // R4
    {3'b0, 1'b0, 8'h80, 4'd15, 16'd4096}, // R2 R4 max
    {3'b0, 1'b0, 8'h06, 4'd2,  16'd24},   // R2 top bit rules
    {3'b0, 1'b1, 8'h01, 4'd0,  16'd4},    // R3
    {3'b0, 1'b1, 8'h40, 4'd1,  16'd512},  // R3
    {3'b0, 1'b1, 8'h80, 4'd0,  16'd256},  // R3 cap
    {3'b0, 1'b1, 8'h00, 4'd4,  16'd5},    // R3 bypass
    {3'b0, 1'b0, 8'h10, 4'd9,  16'd320}   // R2 R4
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic stop_clk();
    @(negedge clk);
    card_clk_en = 1'b0;
    periph_clk_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic start_clk(input bit ddr, input logic [7:0] p, input logic [3:0] d);
    presc_field = p;
    div_field = d;
    ddr_sel = ddr;
    @(negedge clk);
    @(negedge clk);
    card_clk_en = 1'b1;
    periph_clk_en = 1'b1;
  endtask

  // edges until the next tick, sampled after each rising edge
  task automatic edges_to_tick(output int k);
    k = 0;
    for (int i = 1; i <= 10000; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (card_tick) begin
        k = i;
        break;
      end
    end
  endtask

  initial begin
    int k;
    int ok_all;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(!card_clk && !card_tick && !clk_stable, "R1 in reset", {card_clk, card_tick, clk_stable}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(!card_clk && !card_tick && !clk_stable, "R1 after reset", {card_clk, card_tick, clk_stable}, 0);

    // Table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      int exp_n;
      exp_n = int'(VEC[v][15:0]);
      stop_clk();
      start_clk(VEC[v][28], VEC[v][27:20], VEC[v][19:16]);
      edges_to_tick(k);
      check(k == exp_n, $sformatf("R5 first tick vec%0d", v), k, exp_n);
      check(card_clk == 1'b1, $sformatf("R6 clk high at tick vec%0d", v), card_clk, 1);
      edges_to_tick(k);
      check(k == exp_n, $sformatf("R5 tick period vec%0d", v), k, exp_n);
      check(card_clk == 1'b0, $sformatf("R6 clk low at tick vec%0d", v), card_clk, 0);
    end

    // R6: card_clk steady between ticks (N=8)
    stop_clk();
    start_clk(1'b0, 8'h01, 4'd3);
    edges_to_tick(k);
    ok_all = 1;
    for (int i = 0; i < 7; i++) begin
      @(posedge clk); @(negedge clk);
      if (card_clk != 1'b1 || card_tick) ok_all = 0;
    end
    check(ok_all == 1, "R6 steady between ticks", ok_all, 1);

    // R8: mid-run field writes ignored, used after restart
    stop_clk();
    start_clk(1'b0, 8'h01, 4'd0);
    edges_to_tick(k);
    @(negedge clk);
    presc_field = 8'h80; div_field = 4'd7; ddr_sel = 1'b1;
    edges_to_tick(k);
    edges_to_tick(k);
    check(k == 2, "R8 period unchanged mid-run", k, 2);
    stop_clk();
    @(negedge clk);
    card_clk_en = 1'b1; periph_clk_en = 1'b1;
    edges_to_tick(k);
    check(k == 2048, "R8 new setting after restart", k, 2048);

    // R9 / R10 settle flag
    stop_clk();
    start_clk(1'b0, 8'h00, 4'd0);
    repeat (STABLE - 1) @(posedge clk);
    @(negedge clk);
    check(!clk_stable, "R9 low before window", clk_stable, 0);
    @(posedge clk); @(negedge clk);
    check(clk_stable, "R9 high at window end", clk_stable, 1);
    periph_clk_en = 1'b0;
    @(posedge clk); @(negedge clk);
    check(!clk_stable, "R10 drop on periph enable", clk_stable, 0);
    check(!card_tick && !card_clk, "R7 stopped after periph drop", {card_tick, card_clk}, 0);

    // R7: only one enable high, no activity
    periph_clk_en = 1'b0; card_clk_en = 1'b1;
    ok_all = 1;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); @(negedge clk);
      if (card_tick || card_clk || clk_stable) ok_all = 0;
    end
    check(ok_all == 1, "R7 card enable alone", ok_all, 1);
    card_clk_en = 1'b0; periph_clk_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); @(negedge clk);
      if (card_tick || card_clk || clk_stable) ok_all = 0;
    end
    check(ok_all == 1, "R7 periph enable alone", ok_all, 1);

    // R10: drop via card enable after settling
    card_clk_en = 1'b1;
    repeat (STABLE + 2) @(posedge clk);
    @(negedge clk);
    check(clk_stable, "R9 settled again", clk_stable, 1);
    card_clk_en = 1'b0;
    @(posedge clk); @(negedge clk);
    check(!clk_stable, "R10 drop on card enable", clk_stable, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule